// File: doc/BRIEF.md
# Multi-Rail Voltage Window Monitor

This block supervises four supply rails from their digitized feedback codes. Each rail has its own reference code. The block derives fixed fractions of that reference and decides whether the feedback sits below an under-voltage limit or above an over-voltage limit. Rail 0 is the memory core and rail 1 is the memory termination rail, which follows a reference of its own. Rail 2 is the chipset core and rail 3 is the chipset/CPU termination rail. A flag changes only after the crossing has been seen on a set number of consecutive valid samples. This keeps single-sample noise from toggling the fault outputs.

Rail 3 also feeds a power-good detector. It has separate rising and falling limits, so it has hysteresis. Its result drives an active-low request that models an open-drain pin: when the request is high, the pin is pulled low. The sequencer allows power-good evaluation only in the working states (S0/S1/S2) and only after it has enabled evaluation. Outside those conditions the pin is held low.

Top module: `rail_window_mon`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every bit of `uv_flag` and `ov_flag` is 0 and `pg_pull_dn` is 1.
- R2: The under-voltage limit is `ceil(ref*N/64)`, with N=55 for rail 1 and N=48 for rails 0, 2 and 3. A sample qualifies as low when `fb < limit`.
- R3: Only rails 0 and 1 have an over-voltage limit, `floor(ref*73/64)`, and a sample qualifies as high when `fb > limit`. `ov_flag` bits 2 and 3 are always 0, and a rail never has its UV and OV flags set together.
- R4: A flag changes state only on the 3rd (PERSIST) consecutive valid sample that argues for the change. A valid sample that argues against the change restarts the count, and cycles where `fb_valid` is low neither count nor restart it.
- R5: While bit i of `mon_en` is low, bits i of `uv_flag` and `ov_flag` read 0 from the next cycle on. Samples taken during that time leave no pending count behind.
- R6: Power-good on rail 3 becomes true after PERSIST samples with `fb >= ceil(ref*60/64)`. It becomes false after PERSIST samples with `fb < ceil(ref*56/64)`. Samples between the two limits keep the current state.
- R7: `pg_pull_dn` is 1 in the cycle after any cycle where `sys_on`, `pg_eval_en` or `mon_en[3]` is low. The power-good state is then cleared, so it must be requalified under R6.
- R8: Each rail is compared with its own field of `ref_code` (rail i at bits [8i+7:8i]) and its own field of `fb_code`. `pg_pull_dn` equals the inverted power-good state one cycle after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_code | input | 32 | Feedback codes, rail i at [8i+7:8i] |
| fb_valid | input | 4 | Per-rail sample strobe |
| ref_code | input | 32 | Reference codes, rail i at [8i+7:8i] |
| mon_en | input | 4 | Per-rail monitor enable |
| sys_on | input | 1 | High in S0/S1/S2 |
| pg_eval_en | input | 1 | Sequencer permission to evaluate power-good |
| uv_flag | output | 4 | Registered under-voltage flags |
| ov_flag | output | 4 | Registered over-voltage flags (bits 2,3 zero) |
| pg_pull_dn | output | 1 | 1 = power-good pin pulled low |

## Verification
On rail 3, the under-voltage filter and the falling side of power-good can complete on the same sample. Both count the same feedback stream. To provoke this, the bench first qualifies power-good and then drives a feedback code below both the 75% limit and the falling limit for PERSIST samples. It then checks that `uv_flag[3]` is set and that `pg_pull_dn` is 1 one cycle later, with neither path delayed or masked by the other. Sweeps of every feedback code against several references judge every limit arithmetically.

// File: rtl/rwm_pkg.sv
package rwm_pkg;
  localparam int NRAIL    = 4;
  localparam int TRK_RAIL = 1;
  localparam int PG_RAIL  = 3;

  function automatic int unsigned thr_ceil(int unsigned r, int unsigned num, int unsigned fbits);
    return (r * num + (32'd1 << fbits) - 32'd1) >> fbits;
  endfunction

  function automatic int unsigned thr_floor(int unsigned r, int unsigned num, int unsigned fbits);
    return (r * num) >> fbits;
  endfunction
endpackage

// File: rtl/rwm_persist.sv
module rwm_persist #(
  parameter int PERSIST = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic smp,
  input  logic set_cond,
  input  logic clr_cond,
  output logic flag
);
  localparam int CNT_W = $clog2(PERSIST) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

  logic [CNT_W-1:0] cnt;
  logic             want;

  assign want = flag ? clr_cond : set_cond;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (smp) begin
      if (want) begin
        if (cnt == LAST) begin
          flag <= ~flag;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R4: counter never passes the persistence window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
  // R4: a flag only moves on a sample, a clear or a reset
  p_flag_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (flag != $past(flag)) |-> ($past(smp) || $past(clr) || $past(rst)));
endmodule

// File: rtl/rwm_rail.sv
module rwm_rail
  import rwm_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int FRAC_BITS = 6,
  parameter int PERSIST   = 3,
  parameter int UV_N      = 48,
  parameter int OV_N      = 73,
  parameter int RISE_N    = 60,
  parameter int FALL_N    = 56,
  parameter bit HAS_OV    = 1'b1,
  parameter bit HAS_PG    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pg_gate,
  input  logic              smp,
  input  logic [CODE_W-1:0] fb,
  input  logic [CODE_W-1:0] ref_c,
  output logic              uv,
  output logic              ov,
  output logic              pg_lvl
);
  localparam int THR_W = CODE_W + 2;

  logic [THR_W-1:0] fb_x;
  logic [THR_W-1:0] uv_thr;
  logic             uv_low;

  assign fb_x   = {2'b00, fb};
  assign uv_thr = THR_W'(thr_ceil(32'(ref_c), UV_N, FRAC_BITS));
  assign uv_low = fb_x < uv_thr;

  rwm_persist #(.PERSIST(PERSIST)) u_uv (
    .clk(clk), .rst(rst), .clr(~en), .smp(smp & en),
    .set_cond(uv_low), .clr_cond(~uv_low), .flag(uv)
  );

  generate
    if (HAS_OV) begin : g_ov
      logic [THR_W-1:0] ov_thr;
      logic             ov_high;
      assign ov_thr  = THR_W'(thr_floor(32'(ref_c), OV_N, FRAC_BITS));
      assign ov_high = fb_x > ov_thr;
      rwm_persist #(.PERSIST(PERSIST)) u_ov (
        .clk(clk), .rst(rst), .clr(~en), .smp(smp & en),
        .set_cond(ov_high), .clr_cond(~ov_high), .flag(ov)
      );
      // R3: a rail is never both under and over its window
      p_uv_ov_excl_r3: assert property (@(posedge clk) disable iff (rst) !(uv && ov));
    end else begin : g_no_ov
      assign ov = 1'b0;
    end

    if (HAS_PG) begin : g_pg
      logic [THR_W-1:0] rise_thr;
      logic [THR_W-1:0] fall_thr;
      assign rise_thr = THR_W'(thr_ceil(32'(ref_c), RISE_N, FRAC_BITS));
      assign fall_thr = THR_W'(thr_ceil(32'(ref_c), FALL_N, FRAC_BITS));
      rwm_persist #(.PERSIST(PERSIST)) u_pg (
        .clk(clk), .rst(rst), .clr(~(en & pg_gate)), .smp(smp & en & pg_gate),
        .set_cond(fb_x >= rise_thr), .clr_cond(fb_x < fall_thr), .flag(pg_lvl)
      );
    end else begin : g_no_pg
      assign pg_lvl = pg_gate & 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rail_window_mon.sv
module rail_window_mon
  import rwm_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int FRAC_BITS = 6,
  parameter int PERSIST   = 3,
  parameter int UV_N      = 48,
  parameter int UV_TRK_N  = 55,
  parameter int OV_N      = 73,
  parameter int RISE_N    = 60,
  parameter int FALL_N    = 56
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NRAIL*CODE_W-1:0]  fb_code,
  input  logic [NRAIL-1:0]         fb_valid,
  input  logic [NRAIL*CODE_W-1:0]  ref_code,
  input  logic [NRAIL-1:0]         mon_en,
  input  logic                     sys_on,
  input  logic                     pg_eval_en,
  output logic [NRAIL-1:0]         uv_flag,
  output logic [NRAIL-1:0]         ov_flag,
  output logic                     pg_pull_dn
);
  logic             pg_gate;
  logic [NRAIL-1:0] pg_lvl_v;

  assign pg_gate = sys_on & pg_eval_en;

  generate
    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
      rwm_rail #(
        .CODE_W(CODE_W), .FRAC_BITS(FRAC_BITS), .PERSIST(PERSIST),
        .UV_N((g == TRK_RAIL) ? UV_TRK_N : UV_N), .OV_N(OV_N),
        .RISE_N(RISE_N), .FALL_N(FALL_N),
        .HAS_OV(g < 2), .HAS_PG(g == PG_RAIL)
      ) u_rail (
        .clk(clk), .rst(rst), .en(mon_en[g]), .pg_gate(pg_gate),
        .smp(fb_valid[g]),
        .fb(fb_code[g*CODE_W +: CODE_W]),
        .ref_c(ref_code[g*CODE_W +: CODE_W]),
        .uv(uv_flag[g]), .ov(ov_flag[g]), .pg_lvl(pg_lvl_v[g])
      );
      // R5: a disabled rail reports no fault
      p_off_rail_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !mon_en[g] |=> (!uv_flag[g] && !ov_flag[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pg_pull_dn <= 1'b1;
    else     pg_pull_dn <= ~((|pg_lvl_v) & pg_gate & mon_en[PG_RAIL]);
  end

  // R7: power-good is forced low outside the permitted states
  p_pg_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!sys_on || !pg_eval_en || !mon_en[PG_RAIL]) |=> pg_pull_dn);
endmodule

// File: tb/sim_rail_window_mon.sv
module sim_rail_window_mon;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int P = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   fb_code, ref_code;
  logic [3:0]    fb_valid = '0, mon_en = '0, uv_flag, ov_flag;
  logic          sys_on = 1'b1, pg_eval_en = 1'b1, pg_pull_dn;
  logic [W-1:0]  fbv [4];
  logic [W-1:0]  refv[4];
  int            checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      fb_code[i*W +: W]  = fbv[i];
      ref_code[i*W +: W] = refv[i];
    end
  end

  rail_window_mon u0 (
    .clk(clk), .rst(rst), .fb_code(fb_code), .fb_valid(fb_valid),
    .ref_code(ref_code), .mon_en(mon_en), .sys_on(sys_on),
    .pg_eval_en(pg_eval_en), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .pg_pull_dn(pg_pull_dn)
  );

  function automatic int cl(int r, int n); return (r * n + 63) / 64; endfunction
  function automatic int fl(int r, int n); return (r * n) / 64; endfunction

  function automatic logic [3:0] exp_uv();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = int'(fbv[i]) < cl(int'(refv[i]), (i == 1) ? 55 : 48);
    return e;
  endfunction

  function automatic logic [3:0] exp_ov();
    logic [3:0] e = '0;
    for (int i = 0; i < 2; i++) e[i] = int'(fbv[i]) > fl(int'(refv[i]), 73);
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_all(int f);
    for (int i = 0; i < 4; i++) fbv[i] = W'(f);
  endtask

  task automatic samples(int n);
    fb_valid = 4'hF;
    repeat (n) @(negedge clk);
    fb_valid = 4'h0;
    @(negedge clk);
  endtask

  task automatic clear_rails();
    mon_en = 4'h0;
    @(negedge clk);
    mon_en = 4'hF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_all(0);
    for (int i = 0; i < 4; i++) refv[i] = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1 uv", 32'(uv_flag), 0);
    chk("R1 ov", 32'(ov_flag), 0);
    chk("R1 pg", 32'(pg_pull_dn), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {uv_flag, ov_flag, 3'b0, pg_pull_dn}, 32'h1);

    // R2 R3 R6: sweep every feedback code against several references
    foreach (refv[k]) refv[k] = 8'd0;
    for (int rsel = 0; rsel < 4; rsel++) begin
      int r;
      r = (rsel == 0) ? 0 : (rsel == 1) ? 101 : (rsel == 2) ? 171 : 255;
      for (int i = 0; i < 4; i++) refv[i] = W'(r);
      for (int f = 0; f < 256; f++) begin
        clear_rails();
        set_all(f);
        samples(P);
        chk("R2 uv sweep", 32'(uv_flag), 32'(exp_uv()));
        chk("R3 ov sweep", 32'(ov_flag), 32'(exp_ov()));
        chk("R6 pg rise sweep", 32'(pg_pull_dn), 32'(!(f >= cl(r, 60))));
      end
    end

    // R4: interrupted run and invalid gaps
    for (int i = 0; i < 4; i++) refv[i] = 8'd200;
    clear_rails();
    set_all(100); samples(P - 1);
    set_all(180); samples(1);
    set_all(100); samples(P - 1);
    chk("R4 interrupted run", 32'(uv_flag[0]), 0);
    repeat (5) @(negedge clk);
    samples(1);
    chk("R4 gaps ignored", 32'(uv_flag[0]), 1);
    set_all(180); samples(P - 1);
    chk("R4 clear pending", 32'(uv_flag[0]), 1);
    samples(1);
    chk("R4 clear done", 32'(uv_flag[0]), 0);

    // R5: monitor disable
    set_all(100); samples(P);
    chk("R5 pre", 32'(uv_flag), 32'hF);
    mon_en = 4'hE;
    @(negedge clk);
    chk("R5 disabled rail cleared", 32'(uv_flag), 32'hE);
    samples(P);
    chk("R5 disabled rail stays clear", 32'(uv_flag), 32'hE);
    mon_en = 4'hF;
    samples(P - 1);
    chk("R5 no pending count", 32'(uv_flag[0]), 0);

    // R6: hysteresis, ref 128 -> rise 120, fall 112, uv 96
    for (int i = 0; i < 4; i++) refv[i] = 8'd128;
    clear_rails();
    set_all(125); samples(P);
    chk("R6 rise", 32'(pg_pull_dn), 0);
    set_all(115); samples(P);
    chk("R6 hold inside band", 32'(pg_pull_dn), 0);
    set_all(110); samples(P - 1);
    chk("R6 fall pending", 32'(pg_pull_dn), 0);
    samples(1);
    chk("R6 fall", 32'(pg_pull_dn), 1);
    set_all(115); samples(P);
    chk("R6 no rise inside band", 32'(pg_pull_dn), 1);

    // UV and power-good fall completing on the same sample
    set_all(125); samples(P);
    chk("R6 requalify", 32'(pg_pull_dn), 0);
    set_all(90); samples(P);
    chk("R2 uv rail3 concurrent", 32'(uv_flag[3]), 1);
    chk("R8 pg drops concurrent", 32'(pg_pull_dn), 1);

    // R7: gating by state, sequencer and monitor enable
    set_all(125); samples(P);
    chk("R7 good before gate", 32'(pg_pull_dn), 0);
    sys_on = 1'b0; @(negedge clk);
    chk("R7 sys_on low", 32'(pg_pull_dn), 1);
    sys_on = 1'b1; @(negedge clk);
    chk("R7 requalify needed", 32'(pg_pull_dn), 1);
    samples(P);
    chk("R7 requalified", 32'(pg_pull_dn), 0);
    pg_eval_en = 1'b0; samples(P);
    chk("R7 pg_eval_en low", 32'(pg_pull_dn), 1);
    pg_eval_en = 1'b1; samples(P);
    mon_en = 4'h7; @(negedge clk);
    chk("R7 rail3 disabled", 32'(pg_pull_dn), 1);
    mon_en = 4'hF;

    // R8: per-rail references
    refv[0] = 8'd200; refv[1] = 8'd100; refv[2] = 8'd200; refv[3] = 8'd200;
    clear_rails();
    set_all(90); samples(P);
    chk("R8 rail1 own ref ok", 32'(uv_flag), 32'(exp_uv()));
    set_all(80); samples(P);
    chk("R8 rail1 own ref low", 32'(uv_flag), 32'(exp_uv()));
    fbv[1] = 8'd120; fbv[0] = 8'd240; samples(P);
    chk("R8 per-rail ov", 32'(ov_flag), 32'(exp_ov()));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule